// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block is the read-side output multiplexer of a byte-wide nonvolatile memory model. It samples the three active-low bus strobes on each clock. When the chip is selected and its output is enabled with write enable high, it drives a byte onto the data bus, together with a drive-enable flag for an external tri-state buffer. When no write is in progress, that byte is the array word at the latched address. When either enable is high, the output is released.

While the internal programming cycle is busy, a read does not return array data. It returns a status byte built from the last byte written. The polling bit carries the complement of that byte's bit 7. The toggle bit changes value after each completed read access. The remaining bits echo the last byte written.

The toggle bit clears at the start of every write cycle. It flips when an access ends, which happens when output enable or chip enable rises. Polling by either method may start at any point in the write cycle. Once busy drops, reads return true array data on all bits.

Top module: `wrpoll_read_mux`

## Requirements
- R1: A read access is recognised when ceN=0, oeN=0 and weN=1 are sampled at a rising clock edge; driveEn is 1 from that edge on.
- R2: When ceN=1, oeN=1 or weN=0 is sampled at an edge, driveEn is 0 and dataOut is 8'h00 from that edge on.
- R3: A read sampled while busy=0 returns arrayData on all eight bits of dataOut.
- R4: A read sampled while busy=1 returns the inverse of lastData bit 7 on dataOut bit 7.
- R5: While busy=1, dataOut bit 6 shows a toggle flag. The flag is cleared in the cycle busy rises from 0 to 1. It inverts once per completed read, where a read is complete when ceN or oeN is sampled high right after a sampled read. Lowering weN while ceN and oeN stay low does not count as completing a read.
- R6: A read sampled while busy=1 returns lastData bits 5 to 0 on dataOut bits 5 to 0.
- R7: A read sampled in the first cycle with busy=0 after a write cycle returns the current arrayData. No status bits appear in that result.
- R8: With rstN low, driveEn is 0 and dataOut is 8'h00 at once, and the toggle flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| arrayData | input | 8 | Array byte at the latched address |
| lastData | input | 8 | Last byte accepted by the write path |
| dataOut | output | 8 | Byte presented on the bus, zero when released |
| driveEn | output | 1 | Enables the external tri-state data driver |

## Verification
The hardest situation to reach is a toggle flag that is already 1 at the moment a new write cycle begins. Only that state shows the clear-on-start rule apart from a flag that never moved. To get there, the stimulus completes an odd number of reads during one busy period. It then drops busy and raises it again with no read in between, and the next status read must show bit 6 at 0. A second subtle case holds ceN and oeN low while weN dips. That must not count as a completed read, so the toggle value seen on the following status read stays unchanged.

// File: rtl/rdpath_pkg.sv
package rdpath_pkg;

  // Strobes passed from the control decoder to the output datapath
  typedef struct packed {
    logic readNow;     // a read access is sampled this cycle
    logic readDone;    // a read access ended (enable released)
    logic writeStart;  // busy rose this cycle
    logic showStatus;  // programming cycle in progress
  } rdStrobes_t;

endpackage

// File: rtl/rdpath_ctrl.sv
module rdpath_ctrl
  import rdpath_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       busy,
  output rdStrobes_t strb
);

  logic readActive;
  logic readQ;
  logic busyQ;

  assign readActive = !ceN && !oeN && weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readQ <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      readQ <= readActive;
      busyQ <= busy;
    end
  end

  always_comb begin
    strb            = '0;
    strb.readNow    = readActive;
    // an access completes when either enable goes high after a read
    strb.readDone   = readQ && (ceN || oeN);
    strb.writeStart = busy && !busyQ;
    strb.showStatus = busy;
  end

endmodule

// File: rtl/rdpath_data.sv
module rdpath_data
  import rdpath_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strb,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] lastData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  localparam logic [DATA_W-1:0] ZERO_BYTE = '0;

  logic              toggleQ;
  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
    end else if (strb.writeStart) begin
      toggleQ <= 1'b0;
    end else if (strb.readDone) begin
      toggleQ <= ~toggleQ;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == POLL_BIT) begin : g_poll
      assign statusByte[i] = ~lastData[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign statusByte[i] = toggleQ;
    end else begin : g_echo
      assign statusByte[i] = lastData[i];
    end
  end

  always_comb begin
    nextByte = ZERO_BYTE;
    if (strb.readNow) begin
      nextByte = strb.showStatus ? statusByte : arrayData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= ZERO_BYTE;
      driveEn <= 1'b0;
    end else begin
      dataOut <= nextByte;
      driveEn <= strb.readNow;
    end
  end

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readNow |=> driveEn);

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.readNow |=> (!driveEn && dataOut == ZERO_BYTE));

  // R4
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readNow && strb.showStatus) |=>
      dataOut[POLL_BIT] == !$past(lastData[POLL_BIT]));

  // R5
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeStart |=> !toggleQ);

  // R7
  true_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readNow && !strb.showStatus) |=> dataOut == $past(arrayData));

endmodule

// File: rtl/wrpoll_read_mux.sv
module wrpoll_read_mux
  import rdpath_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              busy,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] lastData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  rdStrobes_t strb;

  rdpath_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ceN  (ceN),
    .oeN  (oeN),
    .weN  (weN),
    .busy (busy),
    .strb (strb)
  );

  rdpath_data #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .arrayData (arrayData),
    .lastData  (lastData),
    .dataOut   (dataOut),
    .driveEn   (driveEn)
  );

endmodule

// File: tb/wrpoll_read_mux_tb.sv
module wrpoll_read_mux_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1, oeN = 1'b1, weN = 1'b1, busy = 1'b0;
  logic [7:0] arrayData = 8'h00, lastData = 8'h00;
  logic [7:0] dataOut;
  logic       driveEn;
  int         nChecks = 0, nFails = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  wrpoll_read_mux u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .busy(busy),
    .arrayData(arrayData), .lastData(lastData), .dataOut(dataOut), .driveEn(driveEn)
  );

  typedef struct packed {
    logic       ce, oe, we, bsy;
    logic [7:0] arr, last;
    logic       expDrv;
    logic [7:0] expData;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0, 8'hA5,8'h00, 1'b1,8'hA5, 4'd3}, // R1 R3 idle read
    '{1'b0,1'b1,1'b1,1'b0, 8'hA5,8'h00, 1'b0,8'h00, 4'd2}, // R2 oeN high
    '{1'b1,1'b0,1'b1,1'b0, 8'hA5,8'h00, 1'b0,8'h00, 4'd2}, // R2 ceN high
    '{1'b0,1'b0,1'b0,1'b0, 8'hA5,8'h00, 1'b0,8'h00, 4'd2}, // R2 weN low
    '{1'b1,1'b1,1'b1,1'b1, 8'hFF,8'h3C, 1'b0,8'h00, 4'd2}, // write starts
    '{1'b0,1'b0,1'b1,1'b1, 8'hFF,8'h3C, 1'b1,8'hBC, 4'd4}, // R4 R6 status
    '{1'b0,1'b1,1'b1,1'b1, 8'hFF,8'h3C, 1'b0,8'h00, 4'd2}, // read ends, flag 1
    '{1'b0,1'b0,1'b1,1'b1, 8'hFF,8'h3C, 1'b1,8'hFC, 4'd5}, // R5 toggled
    '{1'b1,1'b0,1'b1,1'b1, 8'hFF,8'h3C, 1'b0,8'h00, 4'd2}, // ceN ends read, flag 0
    '{1'b0,1'b0,1'b1,1'b1, 8'h00,8'hC3, 1'b1,8'h03, 4'd4}, // R4 R6 other byte
    '{1'b0,1'b0,1'b0,1'b1, 8'h00,8'hC3, 1'b0,8'h00, 4'd2}, // weN dip, not completion
    '{1'b0,1'b0,1'b1,1'b1, 8'h00,8'hC3, 1'b1,8'h03, 4'd5}, // R5 flag unchanged
    '{1'b0,1'b0,1'b1,1'b0, 8'h5A,8'hC3, 1'b1,8'h5A, 4'd7}, // R7 busy just fell
    '{1'b0,1'b1,1'b1,1'b0, 8'h5A,8'hC3, 1'b0,8'h00, 4'd2}, // read ends, flag 1
    '{1'b1,1'b1,1'b1,1'b1, 8'h5A,8'h80, 1'b0,8'h00, 4'd2}, // new write clears flag
    '{1'b0,1'b0,1'b1,1'b1, 8'h5A,8'h80, 1'b1,8'h00, 4'd5}, // R5 cleared on start
    '{1'b0,1'b1,1'b1,1'b1, 8'h5A,8'h80, 1'b0,8'h00, 4'd2}, // read ends, flag 1
    '{1'b0,1'b0,1'b1,1'b1, 8'h5A,8'h80, 1'b1,8'h40, 4'd5}, // R5 toggled again
    '{1'b0,1'b0,1'b1,1'b0, 8'h77,8'h80, 1'b1,8'h77, 4'd7}, // R7 true data
    '{1'b1,1'b1,1'b1,1'b0, 8'h77,8'h80, 1'b0,8'h00, 4'd2}  // R2 released
  };

  task automatic check(input string tag, input logic expDrv, input logic [7:0] expData);
    nChecks++;
    if (driveEn !== expDrv || dataOut !== expData) begin
      nFails++;
      $display("FAIL %s: driveEn=%b dataOut=%h expected driveEn=%b dataOut=%h",
               tag, driveEn, dataOut, expDrv, expData);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    #1;
    check("R8", 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ceN = VEC[i].ce; oeN = VEC[i].oe; weN = VEC[i].we; busy = VEC[i].bsy;
      arrayData = VEC[i].arr; lastData = VEC[i].last;
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].expDrv, VEC[i].expData);
    end

    // R3 continuous idle read follows array changes
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; busy = 1'b0; arrayData = 8'hAA;
    @(posedge clk); #1;
    check("R3", 1'b1, 8'hAA);
    @(negedge clk);
    arrayData = 8'h55;
    @(posedge clk); #1;
    check("R3", 1'b1, 8'h55);

    // R8 reset while driving, then flag cleared after odd completed reads
    @(negedge clk);
    busy = 1'b1; lastData = 8'h00;
    @(negedge clk);
    oeN = 1'b1;                 // completes a read during busy, flag 1
    @(negedge clk);
    oeN = 1'b0;
    @(posedge clk); #1;
    check("R5", 1'b1, 8'hC0);
    rstN = 1'b0;
    #1;
    check("R8", 1'b0, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    oeN = 1'b1;                 // busy stays high: start seen after reset
    @(negedge clk);
    oeN = 1'b0;
    @(posedge clk); #1;
    check("R8", 1'b1, 8'h80);

    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1; busy = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule